// File: doc/BRIEF.md
# Stack Machine Fetch-Execute Core

This block is a small processor that runs a 22-opcode stack-machine instruction set. It has one word-addressed data stack that grows toward lower addresses and a separate instruction memory. Every instruction is handled in two phases. The fetch phase latches the word at PC into IR and advances PC. The execute phase then carries out the operation on the data stack, on the eight-entry register file, or on the control registers. Procedure calls build an activation record of three words: a static link, a dynamic link and a return address. Returns take that record down again. Variable access walks the static-link chain a given number of levels and then subtracts an offset from the base it reaches.

The instruction memory is filled through a plain write port, normally while the core is held in reset. Console traffic uses two paths. Output is a single-cycle data strobe. Input is a valid handshake, and the core waits in the execute phase until it is served. The core stops on a halt call, on an undefined opcode, or when PC leaves the instruction memory. It then stays idle until reset.

Top module: `stack_core`

## Requirements
- R1: While reset is asserted and just after it is released, PC is 0, SP is 1000, BP is 999, halted, error and out_valid are low, and every register-file entry and stack word reads as zero.
- R2: An instruction word holds the opcode in bits 31:24, R in bits 23:21, L in bits 20:16 and M in bits 15:0. M is zero-extended. A register operand held in L or M uses its low three bits. A fetch advances PC by one before execution, and an instruction that does not stall takes two cycles.
- R3: Opcodes 11 to 14 and 16 write RF[R] from RF[L] op RF[M]. These are add, subtract, multiply, divide and remainder, all signed 32-bit; division truncates toward zero. Opcode 10 negates RF[R], and opcode 1 loads M into RF[R].
- R4: Opcodes 17 to 22 write 1 or 0 into RF[R] for the signed comparisons equal, not-equal, less, less-or-equal, greater and greater-or-equal of RF[L] against RF[M]. Opcode 15 replaces RF[R] with its lowest bit.
- R5: A divide or remainder with a zero divisor writes 0 to RF[R] and sets error. Once set, error stays high until reset.
- R6: Call (opcode 5) writes three words: the base found L levels up goes to stack[SP-1], BP goes to stack[SP-2] and the advanced PC goes to stack[SP-3]. It then sets BP to SP-1 and PC to M. Return (opcode 2) sets SP to BP+1 and restores BP from stack[SP-2] and PC from stack[SP-3].
- R7: Load (opcode 3) and store (opcode 4) move data between RF[R] and stack[base - M]. The base is reached from BP by following stack[base] L times. Opcode 6 subtracts M from SP.
- R8: Opcode 7 always jumps to M. Opcode 8 jumps to M only when RF[R] is zero.
- R9: Opcode 9 with M=1 drives RF[R] on out_data and raises out_valid for exactly one cycle.
- R10: Opcode 9 with M=2 holds in_ready high and PC steady until in_valid is seen. It then copies in_data into RF[R].
- R11: Opcode 9 with M=3 raises halted. Once halted, the core stays halted with PC unchanged and produces no output until reset.
- R12: An opcode of 0 or above 22, opcode 9 with any other M, or a fetch at a PC of 500 or more halts the core and sets error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write strobe for instruction memory |
| load_addr | input | 9 | Instruction memory write address |
| load_data | input | 32 | Instruction word to write |
| in_valid | input | 1 | Console input word is present |
| in_data | input | 32 | Console input word |
| in_ready | output | 1 | Core is waiting for console input |
| out_valid | output | 1 | One-cycle strobe for console output |
| out_data | output | 32 | Console output word |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Sticky fault flag |
| pc_o | output | 32 | Program counter |
| bp_o | output | 32 | Base pointer |
| sp_o | output | 32 | Stack pointer |

## Verification
The properties assume that in_valid is only meaningful while in_ready is high. They also assume the instruction memory is written only while the core is in reset, so the program does not change under a running core. The bench loads every program before it releases reset. It raises in_valid only after it has seen in_ready, and only for one cycle. All programs keep stack addresses inside the 1000-word array and avoid the overflowing case of dividing the most negative value by minus one.

// File: rtl/stack_core.sv
module stack_core #(
  parameter int DW = 32,
  parameter int STACK_WORDS = 1000,
  parameter int CODE_WORDS = 500,
  parameter int MAX_LEVELS = 31
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_en,
  input  logic [$clog2(CODE_WORDS)-1:0] load_addr,
  input  logic [31:0]                   load_data,
  input  logic                          in_valid,
  input  logic [DW-1:0]                 in_data,
  output logic                          in_ready,
  output logic                          out_valid,
  output logic [DW-1:0]                 out_data,
  output logic                          halted,
  output logic                          error,
  output logic [DW-1:0]                 pc_o,
  output logic [DW-1:0]                 bp_o,
  output logic [DW-1:0]                 sp_o
);
  localparam int SAW = $clog2(STACK_WORDS);
  localparam int CAW = $clog2(CODE_WORDS);

  typedef enum logic [1:0] {PH_FETCH, PH_EXEC, PH_STOP} phase_t;

  logic [31:0]   code_mem [CODE_WORDS];
  logic [DW-1:0] stk [STACK_WORDS];
  logic [DW-1:0] rf [8];
  logic [31:0]   ir;
  logic [DW-1:0] pc, bp, sp;
  phase_t        ph;

  wire [7:0]    op     = ir[31:24];
  wire [2:0]    ri     = ir[23:21];
  wire [4:0]    lfield = ir[20:16];
  wire [15:0]   m      = ir[15:0];
  wire [DW-1:0] mz     = {{(DW-16){1'b0}}, m};
  wire [DW-1:0] va     = rf[lfield[2:0]];
  wire [DW-1:0] vb     = rf[m[2:0]];
  wire [DW-1:0] vr     = rf[ri];

  function automatic logic [SAW-1:0] ix(input logic [DW-1:0] a);
    return a[SAW-1:0];
  endfunction

  always_ff @(posedge clk)
    if (load_en) code_mem[load_addr] <= load_data;

  logic [DW-1:0] base_q;
  always_comb begin
    base_q = bp;
    for (int i = 0; i < MAX_LEVELS; i++)
      if (i < int'(lfield)) base_q = stk[ix(base_q)];
  end
  wire [DW-1:0] mem_addr = base_q - mz;

  logic [DW-1:0] res;
  logic          div0;
  always_comb begin
    res  = '0;
    div0 = 1'b0;
    case (op)
      8'd10: res = -vr;
      8'd11: res = va + vb;
      8'd12: res = va - vb;
      8'd13: res = va * vb;
      8'd14: if (vb == '0) div0 = 1'b1; else res = $signed(va) / $signed(vb);
      8'd15: res = {{(DW-1){1'b0}}, vr[0]};
      8'd16: if (vb == '0) div0 = 1'b1; else res = $signed(va) % $signed(vb);
      8'd17: res = {{(DW-1){1'b0}}, va == vb};
      8'd18: res = {{(DW-1){1'b0}}, va != vb};
      8'd19: res = {{(DW-1){1'b0}}, $signed(va) <  $signed(vb)};
      8'd20: res = {{(DW-1){1'b0}}, $signed(va) <= $signed(vb)};
      8'd21: res = {{(DW-1){1'b0}}, $signed(va) >  $signed(vb)};
      8'd22: res = {{(DW-1){1'b0}}, $signed(va) >= $signed(vb)};
      default: res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_FETCH;
      pc        <= '0;
      sp        <= DW'(STACK_WORDS);
      bp        <= DW'(STACK_WORDS - 1);
      ir        <= '0;
      error     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
      for (int i = 0; i < STACK_WORDS; i++) stk[i] <= '0;
    end else begin
      out_valid <= 1'b0;
      case (ph)
        PH_FETCH:
          if (pc >= DW'(CODE_WORDS)) begin
            ph    <= PH_STOP;
            error <= 1'b1;
          end else begin
            ir <= code_mem[pc[CAW-1:0]];
            pc <= pc + 1'b1;
            ph <= PH_EXEC;
          end
        PH_EXEC: begin
          ph <= PH_FETCH;
          case (op)
            8'd1: rf[ri] <= mz;
            8'd2: begin
              sp <= bp + 1'b1;
              bp <= stk[ix(bp - 1'b1)];
              pc <= stk[ix(bp - 2'd2)];
            end
            8'd3: rf[ri] <= stk[ix(mem_addr)];
            8'd4: stk[ix(mem_addr)] <= vr;
            8'd5: begin
              stk[ix(sp - 1'b1)] <= base_q;
              stk[ix(sp - 2'd2)] <= bp;
              stk[ix(sp - 2'd3)] <= pc;
              bp <= sp - 1'b1;
              pc <= mz;
            end
            8'd6: sp <= sp - mz;
            8'd7: pc <= mz;
            8'd8: if (vr == '0) pc <= mz;
            8'd9:
              case (m)
                16'd1: begin
                  out_valid <= 1'b1;
                  out_data  <= vr;
                end
                16'd2:
                  if (in_valid) rf[ri] <= in_data;
                  else ph <= PH_EXEC;
                16'd3: ph <= PH_STOP;
                default: begin
                  ph    <= PH_STOP;
                  error <= 1'b1;
                end
              endcase
            8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd15, 8'd16,
            8'd17, 8'd18, 8'd19, 8'd20, 8'd21, 8'd22: begin
              rf[ri] <= res;
              if (div0) error <= 1'b1;
            end
            default: begin
              ph    <= PH_STOP;
              error <= 1'b1;
            end
          endcase
        end
        default: ph <= PH_STOP;
      endcase
    end
  end

  assign in_ready = (ph == PH_EXEC) && (op == 8'd9) && (m == 16'd2);
  assign halted   = (ph == PH_STOP);
  assign pc_o     = pc;
  assign bp_o     = bp;
  assign sp_o     = sp;
endmodule

module stack_core_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          halted,
  input logic          error,
  input logic [DW-1:0] pc_o
);
  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc_o));
  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !out_valid && !in_ready);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error);
  // R9
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R10
  stall_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready && $stable(pc_o));
  // R10
  input_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> !in_ready);
endmodule

bind stack_core stack_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .halted(halted), .error(error), .pc_o(pc_o)
);

// File: tb/stack_core_tb.sv
module stack_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [8:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, halted, error;
  logic [31:0] out_data, pc_o, bp_o, sp_o;

  int checks = 0;
  int failures = 0;
  int naddr = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  stack_core u_dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .halted(halted), .error(error), .pc_o(pc_o), .bp_o(bp_o), .sp_o(sp_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int r, input int l, input int m);
    return {op[7:0], r[2:0], l[4:0], m[15:0]};
  endfunction

  task automatic emit(input int op, input int r, input int l, input int m);
    load_en   = 1'b1;
    load_addr = naddr[8:0];
    load_data = enc(op, r, l, m);
    @(negedge clk);
    load_en = 1'b0;
    naddr++;
  endtask

  task automatic expect_out(input int r, input int v, input string tag);
    emit(9, r, 0, 1);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic op_out(input int op, input int r, input int l, input int m,
                        input int v, input string tag);
    emit(op, r, l, m);
    expect_out(r, v, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R9: got %0d expected no output", $signed(out_data));
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, $signed(out_data), e);
      end
    end
  end

  task automatic begin_prog();
    rst_n = 1'b0;
    naddr = 0;
    @(negedge clk);
  endtask

  task automatic release_and_check_reset();
    check("R1 pc", pc_o, 0);
    check("R1 sp", sp_o, 1000);
    check("R1 bp", bp_o, 999);
    check("R1 flags", {halted, error, out_valid, in_ready}, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt(input string tag);
    for (int i = 0; i < 5000 && !halted; i++) @(negedge clk);
    check({tag, " halted"}, halted, 1);
  endtask

  task automatic hold_check();
    int p;
    p = pc_o;
    repeat (4) @(negedge clk);
    check("R11 halt holds", halted, 1);
    check("R11 pc frozen", pc_o, p);
  endtask

  task automatic supply(input int v, input int stall_pc);
    for (int i = 0; i < 2000 && !in_ready; i++) @(negedge clk);
    check("R10 in_ready", in_ready, 1);
    repeat (3) @(negedge clk);
    check("R10 still waiting", in_ready, 1);
    check("R10 pc held", pc_o, stall_pc);
    in_valid = 1'b1;
    in_data  = v;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 ready drops", in_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // Program A: arithmetic, comparisons, divide-by-zero
    begin_prog();
    expect_out(5, 0, "R1 reg zero");
    emit(1, 1, 0, 7);
    emit(1, 2, 0, 5);
    op_out(11, 3, 1, 2, 12, "R3 add");
    op_out(12, 3, 1, 2, 2, "R3 sub");
    op_out(13, 3, 1, 2, 35, "R3 mul");
    op_out(14, 3, 1, 2, 1, "R3 div");
    op_out(16, 3, 1, 2, 2, "R3 mod");
    op_out(10, 1, 0, 0, -7, "R3 neg");
    op_out(14, 3, 1, 2, -1, "R3 signed div");
    op_out(16, 3, 1, 2, -2, "R3 signed mod");
    op_out(19, 3, 1, 2, 1, "R4 lss signed");
    op_out(17, 3, 1, 2, 0, "R4 eql");
    op_out(18, 3, 1, 2, 1, "R4 neq");
    op_out(20, 3, 1, 2, 1, "R4 leq");
    op_out(21, 3, 1, 2, 0, "R4 gtr");
    op_out(22, 3, 1, 2, 0, "R4 geq");
    op_out(17, 3, 2, 2, 1, "R4 eql same");
    op_out(15, 2, 0, 0, 1, "R4 odd");
    emit(1, 4, 0, 0);
    emit(1, 3, 0, 99);
    op_out(14, 3, 2, 4, 0, "R5 div by zero");
    emit(9, 0, 0, 3);
    release_and_check_reset();
    wait_halt("R11 A");
    check("R5 error set", error, 1);
    check("R2 final pc A", pc_o, naddr);
    hold_check();
    check("R9 all outputs seen A", exp_q.size(), 0);

    // Program B: call, return, level walk
    begin_prog();
    emit(7, 0, 0, 9);
    emit(6, 0, 0, 4);
    emit(3, 3, 0, 2);
    expect_out(3, 13, "R6 return address");
    emit(3, 4, 1, 3);
    expect_out(4, 3, "R7 load one level up");
    emit(1, 0, 0, 1);
    emit(4, 0, 1, 3);
    emit(2, 0, 0, 0);
    emit(6, 0, 0, 5);
    emit(1, 0, 0, 3);
    emit(4, 0, 0, 3);
    emit(5, 0, 0, 1);
    emit(3, 1, 0, 3);
    expect_out(1, 1, "R7 store one level up");
    emit(9, 0, 0, 3);
    release_and_check_reset();
    wait_halt("R6 B");
    check("R6 pc after return", pc_o, 16);
    check("R6 bp restored", bp_o, 999);
    check("R6 sp after return", sp_o, 995);
    check("R5 no spurious error", error, 0);
    check("R9 all outputs seen B", exp_q.size(), 0);

    // Program C: jumps, console input, bad opcode
    begin_prog();
    expect_out(3, 0, "R1 reg cleared");
    emit(3, 6, 0, 3);
    expect_out(6, 0, "R1 stack cleared");
    emit(9, 1, 0, 2);
    emit(8, 1, 0, 7);
    emit(1, 2, 0, 77);
    expect_out(2, 77, "R8 jpc taken skipped");
    emit(1, 2, 0, 5);
    emit(8, 2, 0, 10);
    exp_q.pop_back();
    tag_q.pop_back();
    expect_out(2, 5, "R8 jpc not taken");
    emit(9, 2, 0, 2);
    expect_out(2, 42, "R10 input value");
    emit(0, 0, 0, 0);
    release_and_check_reset();
    supply(0, 4);
    supply(42, 11);
    wait_halt("R12 C");
    check("R12 error", error, 1);
    check("R12 pc", pc_o, 13);
    hold_check();
    check("R9 all outputs seen C", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule